// File: doc/BRIEF.md
# Runtime-Endianness Load/Store Data Path

This block sits between a 64-bit core datapath that always computes on little-endian values and a 64-bit data memory port. Each load or store request carries an access size (1, 2, 4 or 8 bytes), a byte offset inside the doubleword, a sign-extension flag for loads and the register data for stores. The block places store bytes on the correct memory lanes with matching byte strobes. It extracts load bytes from the returned doubleword and extends them to 64 bits. In big-endian mode the bytes of each access are reversed within the access width. Store data is reversed before it leaves, and load data is reversed when it arrives and before extension. Instruction fetch never passes through this path, so fetches stay little-endian whatever the mode says.

The mode lives in a small machine status register. A CSR-style port can write it, set bits in it or clear bits in it. The register reads back as a 64-bit word: the machine big-endian bit is at position 37, and copies of it appear at positions 36 (supervisor) and 6 (user). Each request captures the mode in force when it is accepted.

Request, memory and load-result traffic use valid/ready handshakes, with one access outstanding at a time. `req_ready` is high only while the block is idle. Once `mem_req_valid` is raised, it and its data and strobes hold until `mem_req_ready`. The memory answers a load with a single-cycle `mem_rsp_valid` pulse, and the block always accepts it. `ld_valid` and `ld_data` hold until `ld_ready`. The CSR port and `req_fault` are plain signals with no handshake.

Top module: `endian_lsu_path`

## Requirements
- R1: After reset the mode is little-endian, `csr_rdata` is 0, `req_ready` is 1, and `mem_req_valid`, `ld_valid` and `req_fault` are 0.
- R2: A CSR operation with `csr_valid` takes effect at the next clock edge. The codes on `csr_op` are 1 = write (the mode bit takes `csr_wdata[37]`), 2 = set (the mode becomes 1 if `csr_wdata[37]` is 1) and 3 = clear (the mode becomes 0 if `csr_wdata[37]` is 1). Code 0 does nothing.
- R3: `csr_rdata` has bits 37, 36 and 6 all equal to the mode bit and every other bit 0.
- R4: A byte access (`req_size` 0) moves the same byte in either mode.
- R5: `req_size` 1, 2 and 3 select 2, 4 and 8 bytes. In big-endian mode those bytes are reversed within the access, and in little-endian mode they are not. For example, memory bytes 44 33 22 11 read as an unsigned word give 0x11223344 in little-endian mode and 0x44332211 in big-endian mode.
- R6: Store data is reversed within its size (in big-endian mode) and then shifted to lane `req_offset`. `mem_be` marks exactly lanes offset to offset+size-1 in both modes, and lanes outside the access carry 0.
- R7: Load bytes are reordered before extension. With `req_sext` set, the fill comes from bit 7 of the most significant byte after reordering. With `req_sext` clear, the fill is zero.
- R8: A request uses the mode held at the clock edge that accepts it. A CSR change at that same edge applies only to later requests, and an access already in flight keeps its mode.
- R9: An offset that is not a multiple of the access size raises `req_fault` for exactly the cycle after acceptance. It makes no memory request and no load result.
- R10: `mem_req_valid` rises the cycle after acceptance and holds, with `mem_be` and `mem_wdata` stable, until `mem_req_ready`. `ld_valid` rises the cycle after the `mem_rsp_valid` edge and holds, with `ld_data` stable, until `ld_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_valid | input | 1 | CSR operation strobe |
| csr_op | input | 2 | 0 none, 1 write, 2 set, 3 clear |
| csr_wdata | input | 64 | CSR operand |
| csr_rdata | output | 64 | Status register read value |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_store | input | 1 | 1 store, 0 load |
| req_size | input | 2 | log2 of access bytes |
| req_offset | input | 3 | Byte offset in the doubleword |
| req_sext | input | 1 | Sign-extend the load result |
| req_wdata | input | 64 | Store data, little-endian, right-aligned |
| req_fault | output | 1 | Misaligned request pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Memory request is a write |
| mem_be | output | 8 | Byte strobes per lane |
| mem_wdata | output | 64 | Write data on memory lanes |
| mem_rsp_valid | input | 1 | Load data pulse from memory |
| mem_rdata | input | 64 | Load data on memory lanes |
| ld_valid | output | 1 | Load result valid |
| ld_ready | input | 1 | Core accepts the load result |
| ld_data | output | 64 | Extended load result |

## Verification
When a request is accepted at a clock edge, `req_fault` (for a misaligned offset) or `mem_req_valid` (for an aligned one) is due in the next cycle. `ld_valid` is due in the cycle after the edge at which `mem_rsp_valid` is sampled, and the bench memory raises that pulse one cycle after it accepts the read. A monitor samples 1 ns after each falling edge. It compares strobes and write data only in cycles where a memory handshake will complete, compares the load result only where the load handshake will complete, and compares faults in the cycle they appear. Because of this, stalls on either ready signal move when an item is compared but never change what is expected. CSR updates are checked on `csr_rdata` in the cycle after the operation.

// File: rtl/endian_lsu_pkg.sv
package endian_lsu_pkg;
  localparam int XLEN   = 64;
  localparam int NBYTES = XLEN / 8;
  localparam int OFF_W  = $clog2(NBYTES);

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} acc_size_e;
  typedef enum logic [1:0] {CSR_NOP = 2'd0, CSR_WRITE = 2'd1, CSR_SET = 2'd2, CSR_CLEAR = 2'd3} csr_op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_WAIT, ST_RESP} lsu_state_e;

  typedef struct packed {
    logic             store;
    acc_size_e        size;
    logic [OFF_W-1:0] off;
    logic             sext;
    logic             be_mode;
  } acc_ctl_t;
endpackage

// File: rtl/endian_mode_csr.sv
module endian_mode_csr
  import endian_lsu_pkg::*;
#(
  parameter int XLEN_P  = XLEN,
  parameter int MBE_POS = 37,
  parameter int SBE_POS = 36,
  parameter int UBE_POS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_valid,
  input  logic [1:0]        csr_op,
  input  logic [XLEN_P-1:0] csr_wdata,
  output logic              mode_be,
  output logic [XLEN_P-1:0] csr_rdata
);
  logic mode_q;
  logic hit;

  assign hit = csr_wdata[MBE_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (csr_valid) begin
      case (csr_op_e'(csr_op))
        CSR_WRITE: mode_q <= hit;
        CSR_SET:   if (hit) mode_q <= 1'b1;
        CSR_CLEAR: if (hit) mode_q <= 1'b0;
        default:   mode_q <= mode_q;
      endcase
    end
  end

  assign mode_be = mode_q;

  // Lower privilege bits mirror the machine bit.
  always_comb begin
    csr_rdata          = '0;
    csr_rdata[MBE_POS] = mode_q;
    csr_rdata[SBE_POS] = mode_q;
    csr_rdata[UBE_POS] = mode_q;
  end

  // R2: write loads the operand bit
  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid && csr_op == CSR_WRITE |=> mode_be == $past(csr_wdata[MBE_POS]));
  // R2: set with the bit forces big-endian
  a_r2_set_forces: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid && csr_op == CSR_SET && csr_wdata[MBE_POS] |=> mode_be);
  // R2: clear with the bit forces little-endian
  a_r2_clear_forces: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid && csr_op == CSR_CLEAR && csr_wdata[MBE_POS] |=> !mode_be);
  // R2: no operation, no change
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_valid |=> $stable(mode_be));
endmodule

// File: rtl/endian_store_align.sv
module endian_store_align
  import endian_lsu_pkg::*;
#(
  parameter int XLEN_P = XLEN,
  localparam int NB    = XLEN_P / 8,
  localparam int OW    = $clog2(NB)
) (
  input  logic [1:0]        size,
  input  logic [OW-1:0]     off,
  input  logic              be_mode,
  input  logic [XLEN_P-1:0] wdata,
  output logic [XLEN_P-1:0] lanes,
  output logic [NB-1:0]     strobe
);
  logic [OW+1:0] nb_w;
  logic [OW+1:0] end_w;

  assign nb_w  = (OW + 2)'(1) << size;
  assign end_w = (OW + 2)'(off) + nb_w;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic          active;
    logic [OW-1:0] rel;
    logic [OW+1:0] rev_w;
    logic [OW-1:0] src;

    assign active = ((OW + 2)'(g) >= (OW + 2)'(off)) && ((OW + 2)'(g) < end_w);
    assign rel    = OW'(g) - off;
    assign rev_w  = nb_w - (OW + 2)'(1) - (OW + 2)'(rel);
    assign src    = be_mode ? rev_w[OW-1:0] : rel;

    assign lanes[8*g +: 8] = active ? wdata[8*src +: 8] : 8'h00;
    assign strobe[g]       = active;
  end
endmodule

// File: rtl/endian_load_extract.sv
module endian_load_extract
  import endian_lsu_pkg::*;
#(
  parameter int XLEN_P = XLEN,
  localparam int NB    = XLEN_P / 8,
  localparam int OW    = $clog2(NB)
) (
  input  logic [1:0]        size,
  input  logic [OW-1:0]     off,
  input  logic              sext,
  input  logic              be_mode,
  input  logic [XLEN_P-1:0] rdata,
  output logic [XLEN_P-1:0] result
);
  logic [OW:0]       nb_w;
  logic [XLEN_P-1:0] picked;
  logic              sign;

  assign nb_w = (OW + 1)'(1) << size;

  for (genvar g = 0; g < NB; g++) begin : g_pick
    logic [OW-1:0] fwd;
    logic [OW:0]   back;
    logic [OW-1:0] rev;

    assign fwd  = off + OW'(g);
    assign back = nb_w - (OW + 1)'(g + 1);
    assign rev  = off + back[OW-1:0];
    assign picked[8*g +: 8] = be_mode ? rdata[8*rev +: 8] : rdata[8*fwd +: 8];
  end

  always_comb begin
    sign   = 1'b0;
    result = '0;
    for (int k = 0; k < NB; k++) begin
      if ((OW + 1)'(k) == nb_w - (OW + 1)'(1)) sign = picked[8*k + 7];
      if ((OW + 1)'(k) < nb_w) result[8*k +: 8] = picked[8*k +: 8];
      else                     result[8*k +: 8] = {8{sext & sign}};
    end
  end

  // R4: a byte access takes its lane unchanged in either mode
  always_comb begin
    if (size == 2'd0) begin
      a_r4_byte_passthrough: assert (result[7:0] == rdata[8*off +: 8]);
    end
  end
endmodule

// File: rtl/endian_lsu_path.sv
module endian_lsu_path
  import endian_lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_valid,
  input  logic [1:0]        csr_op,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic              req_sext,
  input  logic [XLEN-1:0]   req_wdata,
  output logic              req_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [NBYTES-1:0] mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [XLEN-1:0]   ld_data
);
  lsu_state_e        state_q;
  acc_ctl_t          ctl_q;
  logic [XLEN-1:0]   st_lanes_q;
  logic [NBYTES-1:0] st_be_q;
  logic [XLEN-1:0]   ld_q;
  logic              fault_q;

  logic              mode_be;
  logic [XLEN-1:0]   st_lanes;
  logic [NBYTES-1:0] st_be;
  logic [XLEN-1:0]   ld_result;
  logic [OFF_W:0]    nb_req;
  logic              misaligned;
  logic              req_fire;

  endian_mode_csr #(.XLEN_P(XLEN)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_valid (csr_valid),
    .csr_op    (csr_op),
    .csr_wdata (csr_wdata),
    .mode_be   (mode_be),
    .csr_rdata (csr_rdata)
  );

  endian_store_align #(.XLEN_P(XLEN)) u_store (
    .size    (req_size),
    .off     (req_offset),
    .be_mode (mode_be),
    .wdata   (req_wdata),
    .lanes   (st_lanes),
    .strobe  (st_be)
  );

  endian_load_extract #(.XLEN_P(XLEN)) u_load (
    .size    (ctl_q.size),
    .off     (ctl_q.off),
    .sext    (ctl_q.sext),
    .be_mode (ctl_q.be_mode),
    .rdata   (mem_rdata),
    .result  (ld_result)
  );

  assign nb_req     = (OFF_W + 1)'(1) << req_size;
  assign misaligned = |(req_offset & (nb_req[OFF_W-1:0] - OFF_W'(1)));
  assign req_ready  = (state_q == ST_IDLE);
  assign req_fire   = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ctl_q      <= '0;
      st_lanes_q <= '0;
      st_be_q    <= '0;
      ld_q       <= '0;
      fault_q    <= 1'b0;
    end else begin
      fault_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (misaligned) begin
              fault_q <= 1'b1;
            end else begin
              ctl_q.store   <= req_store;
              ctl_q.size    <= acc_size_e'(req_size);
              ctl_q.off     <= req_offset;
              ctl_q.sext    <= req_sext;
              ctl_q.be_mode <= mode_be;
              st_lanes_q    <= req_store ? st_lanes : '0;
              st_be_q       <= st_be;
              state_q       <= ST_MEM;
            end
          end
        end
        ST_MEM: begin
          if (mem_req_ready) state_q <= ctl_q.store ? ST_IDLE : ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            ld_q    <= ld_result;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (ld_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state_q == ST_MEM);
  assign mem_we        = ctl_q.store;
  assign mem_be        = st_be_q;
  assign mem_wdata     = st_lanes_q;
  assign ld_valid      = (state_q == ST_RESP);
  assign ld_data       = ld_q;
  assign req_fault     = fault_q;

  // R9: misaligned request faults and makes no memory request
  a_r9_fault_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && misaligned |=> req_fault && !mem_req_valid && !ld_valid);
  // R10: memory request and its payload hold while stalled
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_be) && $stable(mem_wdata));
  // R10: load result holds while stalled
  a_r10_ld_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_ready |=> ld_valid && $stable(ld_data));
  // R6: strobes count the access bytes
  a_r6_strobe_count: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> $countones(mem_be) == (32'd1 << ctl_q.size));
  // R8: an access in flight keeps the mode it was accepted with
  a_r8_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MEM || state_q == ST_WAIT) |=> $stable(ctl_q.be_mode));
endmodule

// File: tb/test_endian_lsu_path.sv
`timescale 1ns/1ps
module test_endian_lsu_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_valid = 1'b0;
  logic [1:0]  csr_op = 2'd0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [2:0]  req_offset = 3'd0;
  logic        req_sext = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        req_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic        mem_we;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rdata;
  logic        ld_valid;
  logic        ld_ready = 1'b1;
  logic [63:0] ld_data;

  always #2.5 clk = ~clk;

  endian_lsu_path i_endian_lsu_path (.*);

  // Memory model: one doubleword, read answer one cycle after the handshake.
  logic [63:0] mem_word = '0;
  logic        pend = 1'b0;
  logic        pre_en = 1'b0;
  logic [63:0] pre_val = '0;
  assign mem_rsp_valid = pend;
  assign mem_rdata     = mem_word;

  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else begin
      pend <= mem_req_valid && mem_req_ready && !mem_we;
      if (pre_en) mem_word <= pre_val;
      else if (mem_req_valid && mem_req_ready && mem_we)
        for (int i = 0; i < 8; i++) if (mem_be[i]) mem_word[8*i +: 8] <= mem_wdata[8*i +: 8];
    end
  end

  typedef struct {
    int          kind;   // 0 store, 1 load, 2 fault
    logic [63:0] data;
    logic [7:0]  be;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          exp_mode = 1'b0;
  logic [63:0] shadow = '0;
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [63:0] rev_bytes(input logic [63:0] v, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r[8*i +: 8] = v[8*(n-1-i) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] size_mask(input int n);
    return (n == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8*n)) - 64'd1);
  endfunction

  function automatic logic [63:0] status_image(input bit m);
    return m ? ((64'd1 << 37) | (64'd1 << 36) | (64'd1 << 6)) : 64'd0;
  endfunction

  task automatic csr_do(input int op, input logic [63:0] wd);
    @(negedge clk);
    csr_valid = 1'b1; csr_op = 2'(op); csr_wdata = wd;
    @(negedge clk);
    csr_valid = 1'b0; csr_op = 2'd0;
    if (op == 1) exp_mode = wd[37];
    else if (op == 2 && wd[37]) exp_mode = 1'b1;
    else if (op == 3 && wd[37]) exp_mode = 1'b0;
  endtask

  task automatic preload(input logic [63:0] v);
    @(negedge clk);
    pre_en = 1'b1; pre_val = v;
    @(negedge clk);
    pre_en = 1'b0;
    shadow = v;
  endtask

  // Driver: computes the expected item, pushes it, drives the request.
  task automatic access(input bit st, input int sz, input int off, input bit sx,
                        input logic [63:0] wd, input string tag,
                        input int cop = 0, input logic [63:0] cwd = 64'd0);
    exp_t        e;
    int          n = 1 << sz;
    logic [63:0] v;
    logic [7:0]  bm;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    bm = 8'(((1 << n) - 1) << off);
    e.tag = tag; e.be = bm;
    if ((off % n) != 0) begin
      e.kind = 2; e.data = '0;
    end else if (st) begin
      v = wd & size_mask(n);
      if (exp_mode) v = rev_bytes(v, n);
      e.kind = 0; e.data = v << (8*off);
      for (int i = 0; i < 8; i++) if (bm[i]) shadow[8*i +: 8] = e.data[8*i +: 8];
    end else begin
      v = (shadow >> (8*off)) & size_mask(n);
      if (exp_mode) v = rev_bytes(v, n);
      if (sx && v[8*n-1] && n < 8) v = v | ~size_mask(n);
      e.kind = 1; e.data = v;
    end
    exp_q.push_back(e);
    req_valid = 1'b1; req_store = st; req_size = 2'(sz);
    req_offset = 3'(off); req_sext = sx; req_wdata = wd;
    if (cop != 0) begin
      csr_valid = 1'b1; csr_op = 2'(cop); csr_wdata = cwd;
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (cop != 0) begin
      csr_valid = 1'b0; csr_op = 2'd0;
      if (cop == 1) exp_mode = cwd[37];
      else if (cop == 2 && cwd[37]) exp_mode = 1'b1;
      else if (cop == 3 && cwd[37]) exp_mode = 1'b0;
    end
  endtask

  task automatic drain;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && req_ready && !ld_valid) break;
    end
  endtask

  // Monitor: compares at handshakes, 1 ns after the falling edge.
  always @(negedge clk) begin
    exp_t e;
    #1;
    if (rst_n && !done) begin
      if (mem_req_valid && mem_req_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected memory request", {56'd0, mem_be}, 64'd0);
        else begin
          e = exp_q[0];
          chk(mem_we == (e.kind == 0), {e.tag, " R6 direction"}, {63'd0, mem_we}, {63'd0, e.kind == 0});
          chk(mem_be == e.be, {e.tag, " R6 strobes"}, {56'd0, mem_be}, {56'd0, e.be});
          if (e.kind == 0) begin
            chk(mem_wdata == e.data, {e.tag, " R6 store lanes"}, mem_wdata, e.data);
            void'(exp_q.pop_front());
          end
        end
      end
      if (ld_valid && ld_ready) begin
        if (exp_q.size() == 0 || exp_q[0].kind != 1) chk(1'b0, "R10 unexpected load result", ld_data, 64'd0);
        else begin
          e = exp_q.pop_front();
          chk(ld_data == e.data, {e.tag, " load result"}, ld_data, e.data);
        end
      end
      if (req_fault) begin
        if (exp_q.size() == 0 || exp_q[0].kind != 2) chk(1'b0, "R9 unexpected fault", 64'd1, 64'd0);
        else begin
          e = exp_q.pop_front();
          chk(!mem_req_valid && !ld_valid, {e.tag, " R9 fault without request"},
              {63'd0, mem_req_valid}, 64'd0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", {63'd0, req_ready}, 64'd1);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
    chk(ld_valid == 1'b0, "R1 ld_valid", {63'd0, ld_valid}, 64'd0);
    chk(req_fault == 1'b0, "R1 req_fault", {63'd0, req_fault}, 64'd0);
    chk(csr_rdata == 64'd0, "R1 csr_rdata", csr_rdata, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 / R3 CSR operations
    csr_do(1, 64'd1 << 37);
    #1 chk(csr_rdata == status_image(1'b1), "R2 R3 write sets", csr_rdata, status_image(1'b1));
    csr_do(3, 64'hFFFF_FFDF_FFFF_FFFF);
    #1 chk(csr_rdata == status_image(1'b1), "R2 clear without bit 37", csr_rdata, status_image(1'b1));
    csr_do(3, 64'd1 << 37);
    #1 chk(csr_rdata == 64'd0, "R2 clear", csr_rdata, 64'd0);
    csr_do(2, 64'hFFFF_FFFF_FFFF_FFFF);
    #1 chk(csr_rdata == status_image(1'b1), "R2 R3 set all ones", csr_rdata, status_image(1'b1));
    csr_do(0, 64'd0);
    #1 chk(csr_rdata == status_image(1'b1), "R2 no-op", csr_rdata, status_image(1'b1));
    csr_do(1, 64'd0);
    #1 chk(csr_rdata == 64'd0, "R2 write zero", csr_rdata, 64'd0);

    // R5 word example in both modes
    preload(64'hF0E1D2C3_11223344);
    access(0, 2, 0, 0, 0, "R5 LE word");
    drain();
    csr_do(2, 64'd1 << 37);
    access(0, 2, 0, 0, 0, "R5 BE word");
    access(0, 2, 4, 1, 0, "R7 BE signed word");
    access(0, 3, 0, 0, 0, "R5 BE double");
    access(0, 1, 6, 1, 0, "R7 BE signed half");
    // R4 bytes in both modes
    access(0, 0, 5, 1, 0, "R4 BE signed byte");
    access(0, 0, 2, 0, 0, "R4 BE byte");
    drain();
    csr_do(3, 64'd1 << 37);
    access(0, 0, 5, 1, 0, "R4 LE signed byte");
    access(0, 1, 6, 1, 0, "R7 LE signed half");
    // R7 sign differs by mode
    preload(64'h0000_0000_0000_7F80);
    access(0, 1, 0, 1, 0, "R7 LE half positive");
    drain();
    csr_do(2, 64'd1 << 37);
    access(0, 1, 0, 1, 0, "R7 BE half negative");
    access(0, 1, 0, 0, 0, "R7 BE half zero-fill");

    // R6 stores in BE then LE, round trip through loads
    access(1, 3, 0, 0, 64'h0102_0304_0506_0708, "R6 BE double store");
    access(1, 2, 4, 0, 64'hFFFF_FFFF_A1B2_C3D4, "R6 BE word store off4");
    access(1, 1, 2, 0, 64'h0000_0000_0000_9A8B, "R6 BE half store off2");
    access(1, 0, 7, 0, 64'h0000_0000_0000_00EE, "R4 R6 BE byte store off7");
    access(0, 2, 4, 0, 0, "R5 BE round trip word");
    access(0, 3, 0, 0, 0, "R5 BE double after stores");
    drain();
    csr_do(3, 64'd1 << 37);
    access(1, 2, 0, 0, 64'h0000_0000_5566_7788, "R6 LE word store");
    access(1, 1, 6, 0, 64'h0000_0000_0000_1234, "R6 LE half store off6");
    access(0, 3, 0, 0, 0, "R5 LE double after stores");

    // R9 misaligned requests
    access(0, 2, 2, 0, 0, "R9 word off2");
    access(1, 1, 1, 0, 64'h55, "R9 half off1");
    access(0, 3, 4, 0, 0, "R9 double off4");
    access(0, 2, 4, 0, 0, "R9 aligned after faults");

    // R8 CSR change at the accepting edge
    access(0, 2, 0, 0, 0, "R8 same-edge set keeps LE", 2, 64'd1 << 37);
    access(0, 2, 0, 0, 0, "R8 next request sees BE");
    drain();

    // R8 in flight while memory stalls, R10 hold
    @(negedge clk);
    mem_req_ready = 1'b0;
    access(0, 2, 4, 0, 0, "R8 in-flight keeps BE");
    csr_do(3, 64'd1 << 37);
    #1 chk(mem_req_valid == 1'b1, "R10 request held under stall", {63'd0, mem_req_valid}, 64'd1);
    @(negedge clk);
    mem_req_ready = 1'b1;
    drain();
    access(0, 2, 4, 0, 0, "R8 later request sees LE");
    drain();

    // R10 load result held while the core stalls
    @(negedge clk);
    ld_ready = 1'b0;
    access(0, 3, 0, 0, 0, "R10 held load");
    repeat (5) @(negedge clk);
    #1 chk(ld_valid == 1'b1, "R10 ld_valid held", {63'd0, ld_valid}, 64'd1);
    @(negedge clk);
    ld_ready = 1'b1;
    drain();

    chk(exp_q.size() == 0, "R10 all items retired", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule